// File: doc/BRIEF.md
# SPI Serial Clock Generator with Programmable Duty

This block derives a serial clock for an SPI transfer engine from the system clock. A period counter runs from zero up to a programmed divider value and then wraps. Two further programmed counts mark the counter value at which the serial clock goes high and the value at which it goes low. Because these two points are set independently, the duty cycle can be anything the divider allows, not only a fixed half-period toggle.

The engine holds `run` high for as long as it wants clocks. While `run` is low the serial clock is parked low and the counter waits at zero. The block also gives the engine a single-cycle strobe with each rising edge and with each falling edge, so that it can shift data out and sample data in. A bypass bit in the configuration word drops the divider and makes the clock toggle on every system clock edge.

Top module: `spi_sck_gen`

## Requirements
- R1: After reset `sck`, `sck_rise` and `sck_fall` are all low.
- R2: In the cycle after any clock edge at which `run` is sampled low, `sck`, `sck_rise` and `sck_fall` are low and the period counter is at 0, so the next run starts again from count 0.
- R3: The configuration word uses bit 31 as the bypass select, bits 17:12 as the divider n, bits 11:6 as the high count and bits 5:0 as the low count.
- R4: While running, the period counter steps through 0 to n and wraps, so the clock period is n+1 system clocks for any n from 1 to 63.
- R5: `sck` is set high by the clock edge at which the counter equals the high count.
- R6: `sck` is set low by the clock edge at which the counter equals the low count.
- R7: When the high and low counts are equal, the low count takes priority: `sck` stays low and no rising strobe is issued.
- R8: `sck_rise` is high for exactly the first cycle in which `sck` reads high, and `sck_fall` for exactly the first cycle in which `sck` reads low again. The two strobes are never high together.
- R9: With the bypass bit set, `sck` toggles on every clock edge while running (first edge high), and the divider, high and low fields have no effect.
- R10: The configuration is captured only while `run` is low. Changes to `cfg` while running have no effect until the next idle period.
- R11: A high or low count greater than n never matches, so `sck` keeps its level across that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | The engine requests clocks while this is high |
| cfg_i | input | 32 | Configuration word (bypass, divider, high count, low count) |
| sck_o | output | 1 | Gated serial clock, idle low |
| sck_rise_o | output | 1 | One-cycle strobe with each rising edge of sck_o |
| sck_fall_o | output | 1 | One-cycle strobe with each falling edge of sck_o |

## Verification
The rise and fall decisions can land in the same cycle when the high and low counts hold the same value. A dedicated case provokes this with both counts at 2 and a divider of 5. The expected stream comes from the rule that the low point wins: `sck` and `sck_rise` must stay low on every cycle. A second collision is between a run request ending and a pending edge. The bench drops `run` while `sck` is high and expects the next cycle to show a low clock with no fall strobe.

// File: rtl/sckgen_pkg.sv
package sckgen_pkg;

   typedef enum logic {
      SRC_DIVIDED = 1'b0,
      SRC_BYPASS  = 1'b1
   } sck_src_e;

endpackage

// File: rtl/sckgen_cfg_hold.sv
module sckgen_cfg_hold
   import sckgen_pkg::*;
#(
   parameter int CFG_W         = 32,
   parameter int DIV_W         = 6,
   parameter int SRC_BIT       = 31,
   parameter int DIV_LSB       = 12,
   parameter int HI_LSB        = 6,
   parameter int LO_LSB        = 0,
   parameter bit ENABLE_BYPASS = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [CFG_W-1:0] cfg_i,
   output logic [DIV_W-1:0] div_o,
   output logic [DIV_W-1:0] hi_o,
   output logic [DIV_W-1:0] lo_o,
   output sck_src_e         src_o
);

   localparam int DIV_MSB = DIV_LSB + DIV_W - 1;
   localparam int HI_MSB  = HI_LSB + DIV_W - 1;
   localparam int LO_MSB  = LO_LSB + DIV_W - 1;

   if (DIV_MSB >= CFG_W || HI_MSB >= CFG_W || LO_MSB >= CFG_W) begin : g_bad_field
      $error("sckgen_cfg_hold: a field lies outside the configuration word");
   end
   if (SRC_BIT >= CFG_W) begin : g_bad_src
      $error("sckgen_cfg_hold: source bit lies outside the configuration word");
   end

   sck_src_e src_d;

   if (ENABLE_BYPASS) begin : g_src_sel
      assign src_d = cfg_i[SRC_BIT] ? SRC_BYPASS : SRC_DIVIDED;
   end else begin : g_src_fixed
      assign src_d = SRC_DIVIDED;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         div_o <= '0;
         hi_o  <= '0;
         lo_o  <= '0;
         src_o <= SRC_DIVIDED;
      end else if (!run_i) begin
         div_o <= cfg_i[DIV_MSB:DIV_LSB];
         hi_o  <= cfg_i[HI_MSB:HI_LSB];
         lo_o  <= cfg_i[LO_MSB:LO_LSB];
         src_o <= src_d;
      end
   end

   // R10: fields stay frozen across consecutive running cycles
   p_cfg_frozen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && $past(run_i)) |-> ($stable(div_o) && $stable(hi_o) && $stable(lo_o) && $stable(src_o)));

endmodule

// File: rtl/sckgen_period_cnt.sv
module sckgen_period_cnt #(
   parameter int DIV_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic [DIV_W-1:0] cnt_o
);

   if (DIV_W < 1) begin : g_bad_width
      $error("sckgen_period_cnt: DIV_W must be at least 1");
   end

   localparam logic [DIV_W-1:0] CNT_ONE = DIV_W'(1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_o <= '0;
      end else if (!run_i) begin
         cnt_o <= '0;
      end else if (cnt_o >= div_i) begin
         cnt_o <= '0;
      end else begin
         cnt_o <= cnt_o + CNT_ONE;
      end
   end

   // R4: the counter never passes the divider value
   p_cnt_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_o <= div_i);

   // R4: reaching the divider value wraps to zero
   p_cnt_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && cnt_o == div_i) |=> (cnt_o == '0));

   // R2: an idle request parks the counter at zero
   p_cnt_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> (cnt_o == '0));

endmodule

// File: rtl/sckgen_edge_gen.sv
module sckgen_edge_gen
   import sckgen_pkg::*;
#(
   parameter int DIV_W = 6
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  sck_src_e         src_i,
   input  logic [DIV_W-1:0] cnt_i,
   input  logic [DIV_W-1:0] hi_i,
   input  logic [DIV_W-1:0] lo_i,
   output logic             sck_o,
   output logic             rise_o,
   output logic             fall_o
);

   logic hit_hi;
   logic hit_lo;
   logic sck_nxt;

   always_comb begin
      hit_hi = (cnt_i == hi_i);
      hit_lo = (cnt_i == lo_i);
      if (src_i == SRC_BYPASS) begin
         sck_nxt = ~sck_o;
      end else if (hit_lo) begin
         sck_nxt = 1'b0;
      end else if (hit_hi) begin
         sck_nxt = 1'b1;
      end else begin
         sck_nxt = sck_o;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sck_o  <= 1'b0;
         rise_o <= 1'b0;
         fall_o <= 1'b0;
      end else if (!run_i) begin
         sck_o  <= 1'b0;
         rise_o <= 1'b0;
         fall_o <= 1'b0;
      end else begin
         sck_o  <= sck_nxt;
         rise_o <= ~sck_o & sck_nxt;
         fall_o <= sck_o & ~sck_nxt;
      end
   end

   // R8: strobes are exclusive
   p_strobe_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rise_o && fall_o));

   // R8: a rise strobe accompanies a clock that just went high
   p_rise_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |-> (sck_o && !$past(sck_o)));

   // R8: a fall strobe accompanies a clock that just went low
   p_fall_edge_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fall_o |-> (!sck_o && $past(sck_o)));

   // R2: idle request parks everything low
   p_idle_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> (!sck_o && !rise_o && !fall_o));

   // R7: equal high and low points never raise the clock
   p_tie_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && src_i == SRC_DIVIDED && hit_hi && hit_lo) |=> (!sck_o && !rise_o));

   // R9: bypass toggles on every running edge
   p_bypass_toggle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_i && src_i == SRC_BYPASS) |=> (sck_o != $past(sck_o)));

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
   import sckgen_pkg::*;
#(
   parameter int CFG_W         = 32,
   parameter int DIV_W         = 6,
   parameter int SRC_BIT       = 31,
   parameter int DIV_LSB       = 12,
   parameter int HI_LSB        = 6,
   parameter int LO_LSB        = 0,
   parameter bit ENABLE_BYPASS = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic [CFG_W-1:0] cfg_i,
   output logic             sck_o,
   output logic             sck_rise_o,
   output logic             sck_fall_o
);

   logic [DIV_W-1:0] div_q;
   logic [DIV_W-1:0] hi_q;
   logic [DIV_W-1:0] lo_q;
   sck_src_e         src_q;
   logic [DIV_W-1:0] cnt_q;

   sckgen_cfg_hold #(
      .CFG_W        (CFG_W),
      .DIV_W        (DIV_W),
      .SRC_BIT      (SRC_BIT),
      .DIV_LSB      (DIV_LSB),
      .HI_LSB       (HI_LSB),
      .LO_LSB       (LO_LSB),
      .ENABLE_BYPASS(ENABLE_BYPASS)
   ) u_cfg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (run_i),
      .cfg_i (cfg_i),
      .div_o (div_q),
      .hi_o  (hi_q),
      .lo_o  (lo_q),
      .src_o (src_q)
   );

   sckgen_period_cnt #(
      .DIV_W(DIV_W)
   ) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (run_i),
      .div_i (div_q),
      .cnt_o (cnt_q)
   );

   sckgen_edge_gen #(
      .DIV_W(DIV_W)
   ) u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .run_i (run_i),
      .src_i (src_q),
      .cnt_i (cnt_q),
      .hi_i  (hi_q),
      .lo_i  (lo_q),
      .sck_o (sck_o),
      .rise_o(sck_rise_o),
      .fall_o(sck_fall_o)
   );

   // R1: outputs low in the first cycle after reset release
   p_reset_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_ni) |-> (!sck_o && !sck_rise_o && !sck_fall_o));

endmodule

// File: tb/sim_spi_sck_gen.sv
`timescale 1ns/1ps
module sim_spi_sck_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        run = 1'b0;
   logic [31:0] cfg = '0;
   logic        sck, rise, fall;

   int n_tests = 0;
   int n_fail  = 0;

   logic [2:0] exp_q[$];
   string      tag_q[$];

   always #10 clk = ~clk;

   spi_sck_gen u0 (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .run_i     (run),
      .cfg_i     (cfg),
      .sck_o     (sck),
      .sck_rise_o(rise),
      .sck_fall_o(fall)
   );

   // R3: word layout used by the bench
   function automatic logic [31:0] mk(input bit byp, input int n, input int hi, input int lo);
      logic [31:0] w = '0;
      w[31]    = byp;
      w[17:12] = 6'(n);
      w[11:6]  = 6'(hi);
      w[5:0]   = 6'(lo);
      return w;
   endfunction

   task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: {sck,rise,fall} got %b expected %b at %0t", tag, got, exp, $time);
      end
   endtask

   // monitor: compare each produced cycle against the queue
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            check(tag_q.pop_front(), {sck, rise, fall}, exp_q.pop_front());
         end
      end
   end

   // driver: pushes the expected stream computed from the requirements
   task automatic run_case(input logic [31:0] c, input int ncyc, input string tag,
                           input int chg_at, input logic [31:0] c2);
      bit byp = c[31];
      int n = int'(c[17:12]);
      int hi = int'(c[11:6]);
      int lo = int'(c[5:0]);
      logic s = 1'b0;
      @(negedge clk);
      cfg = c;
      run = 1'b0;
      repeat (2) @(negedge clk);
      for (int k = 0; k < ncyc; k++) begin
         int cnt = k % (n + 1);
         logic nx;
         if (byp) nx = ~s;
         else if (cnt == lo) nx = 1'b0;
         else if (cnt == hi) nx = 1'b1;
         else nx = s;
         exp_q.push_back({nx, ~s & nx, s & ~nx});
         tag_q.push_back(tag);
         s = nx;
      end
      run = 1'b1;
      for (int k = 0; k < ncyc; k++) begin
         if (k == chg_at) cfg = c2;
         @(negedge clk);
      end
      run = 1'b0;
      for (int k = 0; k < 2; k++) begin
         exp_q.push_back(3'b000);
         tag_q.push_back("R2 idle after run");
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 reset", {sck, rise, fall}, 3'b000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {sck, rise, fall}, 3'b000);

      run_case(mk(0, 3, 1, 3),  20, "R5 R6 R8 n3",            -1, '0);
      run_case(mk(0, 4, 1, 4),  23, "R4 R5 R6 n4",            -1, '0);
      run_case(mk(0, 1, 0, 1),  12, "R4 n1 fastest",          -1, '0);
      run_case(mk(0, 63, 31, 63), 140, "R4 n63 slowest",      -1, '0);
      run_case(mk(0, 5, 4, 1),  20, "R6 R8 low before high", -1, '0);
      run_case(mk(0, 5, 2, 2),  18, "R7 equal points",        -1, '0);
      run_case(mk(0, 3, 1, 10), 12, "R11 low beyond n",       -1, '0);
      run_case(mk(0, 3, 9, 2),  12, "R11 high beyond n",      -1, '0);
      run_case(mk(1, 5, 2, 4),  11, "R9 bypass",              -1, '0);
      run_case(mk(0, 3, 1, 3),  24, "R10 cfg change ignored", 5, mk(1, 1, 0, 1));
      // R2: stop while high (n=3 hi=1 lo=3: high after edges 2..3)
      run_case(mk(0, 3, 1, 3),  3,  "R2 stop mid high",       -1, '0);
      run_case(mk(0, 3, 1, 3),  9,  "R2 restart from zero",   -1, '0);

      repeat (4) @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule